// File: doc/BRIEF.md
# Torus Link Packet Send Port

This block is the processor-facing end of a nearest-neighbour torus network node. Software builds each packet by writing 128-bit quadwords straight into one of six per-direction send queues, one queue for each of the plus and minus neighbours in x, y and z. Every packet goes exactly one hop. The software sequence is fixed:

- reserve room for N data quadwords in the chosen queue;
- push one header quadword;
- push up to N data quadwords;
- issue a commit that releases the whole packet to the link side at once.

A send never stalls the processor once the reservation has been granted. Packet data is capped at 14 quadwords (224 bytes), so a 192-byte site payload of 12 quadwords fits in one packet.

A small receive deframer sits beside the send path. It takes one incoming link stream, reads the length field of each header and discards the header. It then hands the payload to a reader, which stalls on a low valid until data arrives. Sends never block; receives do.

The send controller has three states. IDLE moves to WAIT_HDR on a granted reservation. WAIT_HDR moves to FILL on the header push. FILL stays in FILL on a data push, and returns to IDLE either on a commit or on an overflowing push, which drops the packet. The receive deframer has two states. HDR moves to BODY when it takes a header with a non-zero length; a zero-length header is consumed and it stays in HDR. BODY returns to HDR when the last payload quadword is taken.

Top module: `torus_link_port`

## Requirements
- R1: Direction codes 0 to 5 select the +x, -x, +y, -y, +z and -z queues, each with its own storage. Codes 6 and 7 are never granted.
- R2: `cpu_resv_ok` is high only in IDLE, with a valid direction, a length of 14 or less, and at least length+1 free entries in that queue. A reservation is taken on `cpu_resv` with `cpu_resv_ok`. A push or commit made while no reservation is held has no effect.
- R3: A packet leaves on its direction's link as the header followed by its data quadwords, in push order.
- R4: Pushed quadwords are invisible on the link until commit. The whole packet becomes visible in the cycle after the commit edge. A commit issued before the header has no effect.
- R5: A data push beyond the reserved count sets `cpu_ovf_err`, discards the packet and returns to IDLE. The error stays set until reset.
- R6: A header carries the direction in bits [2:0] and the data length in bits [7:4]. The receiver strips the header, delivers exactly that many quadwords, and raises `rd_last` on the final one.
- R7: `rd_valid` stays low until payload is present. A zero-length packet delivers nothing to the reader.
- R8: A link output holds `link_valid` and keeps its quadword stable until `link_ready` is seen. The six directions drain independently.
- R9: After reset all queues are empty, `link_valid` and `rd_valid` are low, `cpu_ovf_err` is clear, and reservations are accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_dir | input | 3 | Direction code for a reservation |
| cpu_resv | input | 1 | Reservation request |
| cpu_len | input | 4 | Data quadwords requested |
| cpu_resv_ok | output | 1 | Room available; reservation would be granted |
| cpu_push | input | 1 | Push one quadword (header first, then data) |
| cpu_qw | input | QW_W | Quadword being pushed |
| cpu_commit | input | 1 | Release the assembled packet |
| cpu_ovf_err | output | 1 | Sticky overflow error |
| link_valid | output | 6 | Per-direction committed data present |
| link_ready | input | 6 | Per-direction link accept |
| link_qw | output | 6*QW_W | Per-direction head quadword, direction d at bits d*QW_W |
| rx_valid_in | input | 1 | Incoming link quadword valid |
| rx_qw_in | input | QW_W | Incoming link quadword |
| rx_ready_out | output | 1 | Incoming quadword accepted |
| rd_valid | output | 1 | Payload quadword available to the reader |
| rd_qw | output | QW_W | Payload quadword |
| rd_last | output | 1 | Final quadword of the packet |
| rd_ready | input | 1 | Reader takes the quadword |

## Verification
Suppose the send controller held a wrong state or count. A premature link_valid would then show in the cycle after a push, or a commit would expose nothing one cycle after its edge. Either shows up directly on the direction's link outputs. A wrong write or release pointer in a queue shows up as wrong, missing or extra payload when the packet is looped back through the deframer. It also shows up as a wrong grant decision on `cpu_resv_ok` as soon as the queue nears full. A wrong deframer count shows as a misplaced `rd_last`, or as a header delivered as payload, within the packet being received.

// File: rtl/torus_link_pkg.sv
package torus_link_pkg;
    localparam int NDIR        = 6;
    localparam int DIR_W       = 3;
    localparam int LEN_W       = 4;
    localparam int HDR_DIR_LSB = 0;
    localparam int HDR_LEN_LSB = 4;

    typedef enum logic [1:0] {
        S_IDLE     = 2'd0,
        S_WAIT_HDR = 2'd1,
        S_FILL     = 2'd2
    } tx_state_e;

    typedef enum logic {
        R_HDR  = 1'b0,
        R_BODY = 1'b1
    } rx_state_e;
endpackage

// File: rtl/torus_tx_fifo.sv
module torus_tx_fifo #(
    parameter int QW_W  = 128,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [QW_W-1:0] wr_qw,
    input  logic            commit,
    input  logic            rewind,
    output logic [PW-1:0]   free_cnt,
    output logic            out_valid,
    output logic [QW_W-1:0] out_qw,
    input  logic            out_ready
);
    logic [QW_W-1:0] mem [DEPTH];
    logic [PW-1:0]   wr_q, pub_q, rd_q;

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_q[AW-1:0]] <= wr_qw;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= '0;
            pub_q <= '0;
            rd_q  <= '0;
        end else begin
            if (rewind)     wr_q <= pub_q;
            else if (wr_en) wr_q <= wr_q + PW'(1);
            if (commit)     pub_q <= wr_q;
            if (out_valid && out_ready) rd_q <= rd_q + PW'(1);
        end
    end

    always_comb begin
        out_valid = (pub_q != rd_q);
        out_qw    = mem[rd_q[AW-1:0]];
        free_cnt  = PW'(DEPTH) - (wr_q - rd_q);
    end
endmodule

// File: rtl/torus_tx_ctrl.sv
module torus_tx_ctrl
    import torus_link_pkg::*;
#(
    parameter int PTR_W    = 5,
    parameter int MAX_DATA = 14
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [DIR_W-1:0]            cpu_dir,
    input  logic                        cpu_resv,
    input  logic [LEN_W-1:0]            cpu_len,
    output logic                        cpu_resv_ok,
    input  logic                        cpu_push,
    input  logic                        cpu_commit,
    output logic                        cpu_ovf_err,
    input  logic [NDIR-1:0][PTR_W-1:0]  free_cnt,
    output logic [NDIR-1:0]             wr_en,
    output logic [NDIR-1:0]             commit,
    output logic [NDIR-1:0]             rewind
);
    tx_state_e        state_q, state_d;
    logic [DIR_W-1:0] dir_q, dir_sel;
    logic [LEN_W-1:0] len_q, cnt_q;
    logic             room, ovf_hit, data_wr;

    always_comb begin
        dir_sel = (cpu_dir < DIR_W'(NDIR)) ? cpu_dir : '0;
        room    = (cpu_dir < DIR_W'(NDIR)) && (cpu_len <= LEN_W'(MAX_DATA))
               && (free_cnt[dir_sel] >= (PTR_W'(cpu_len) + PTR_W'(1)));
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:     if (cpu_resv && room) state_d = S_WAIT_HDR;
            S_WAIT_HDR: if (cpu_push) state_d = S_FILL;
            S_FILL: begin
                if (cpu_commit) state_d = S_IDLE;
                else if (cpu_push && (cnt_q == len_q)) state_d = S_IDLE;
            end
            default:    state_d = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        wr_en       = '0;
        commit      = '0;
        rewind      = '0;
        ovf_hit     = 1'b0;
        data_wr     = 1'b0;
        cpu_resv_ok = (state_q == S_IDLE) && room;
        unique case (state_q)
            S_IDLE: ;
            S_WAIT_HDR: if (cpu_push) wr_en[dir_q] = 1'b1;
            S_FILL: begin
                if (cpu_commit) begin
                    commit[dir_q] = 1'b1;
                end else if (cpu_push) begin
                    if (cnt_q == len_q) begin
                        rewind[dir_q] = 1'b1;
                        ovf_hit       = 1'b1;
                    end else begin
                        wr_en[dir_q] = 1'b1;
                        data_wr      = 1'b1;
                    end
                end
            end
            default: ;
        endcase
    end

    // state register and per-packet bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= S_IDLE;
            dir_q       <= '0;
            len_q       <= '0;
            cnt_q       <= '0;
            cpu_ovf_err <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && cpu_resv && room) begin
                dir_q <= cpu_dir;
                len_q <= cpu_len;
                cnt_q <= '0;
            end else if (data_wr) begin
                cnt_q <= cnt_q + LEN_W'(1);
            end
            if (ovf_hit) cpu_ovf_err <= 1'b1;
        end
    end
endmodule

// File: rtl/torus_rx_deframer.sv
module torus_rx_deframer
    import torus_link_pkg::*;
#(
    parameter int QW_W = 128
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rx_valid_in,
    input  logic [QW_W-1:0] rx_qw_in,
    output logic            rx_ready_out,
    output logic            rd_valid,
    output logic [QW_W-1:0] rd_qw,
    output logic            rd_last,
    input  logic            rd_ready
);
    rx_state_e        st_q, st_d;
    logic [LEN_W-1:0] left_q, hdr_len;

    assign hdr_len = rx_qw_in[HDR_LEN_LSB +: LEN_W];

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            R_HDR:  if (rx_valid_in && hdr_len != '0) st_d = R_BODY;
            R_BODY: if (rx_valid_in && rd_ready && left_q == LEN_W'(1)) st_d = R_HDR;
            default: st_d = R_HDR;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= R_HDR;
            left_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == R_HDR && rx_valid_in) left_q <= hdr_len;
            else if (st_q == R_BODY && rx_valid_in && rd_ready) left_q <= left_q - LEN_W'(1);
        end
    end

    always_comb begin
        rx_ready_out = (st_q == R_HDR) ? 1'b1 : rd_ready;
        rd_valid     = (st_q == R_BODY) && rx_valid_in;
        rd_last      = (st_q == R_BODY) && (left_q == LEN_W'(1));
        rd_qw        = rx_qw_in;
    end
endmodule

// File: rtl/torus_link_port.sv
module torus_link_port
    import torus_link_pkg::*;
#(
    parameter int QW_W     = 128,
    parameter int DEPTH    = 16,
    parameter int MAX_DATA = 14
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2:0]           cpu_dir,
    input  logic                 cpu_resv,
    input  logic [3:0]           cpu_len,
    output logic                 cpu_resv_ok,
    input  logic                 cpu_push,
    input  logic [QW_W-1:0]      cpu_qw,
    input  logic                 cpu_commit,
    output logic                 cpu_ovf_err,
    output logic [5:0]           link_valid,
    input  logic [5:0]           link_ready,
    output logic [6*QW_W-1:0]    link_qw,
    input  logic                 rx_valid_in,
    input  logic [QW_W-1:0]      rx_qw_in,
    output logic                 rx_ready_out,
    output logic                 rd_valid,
    output logic [QW_W-1:0]      rd_qw,
    output logic                 rd_last,
    input  logic                 rd_ready
);
    localparam int PTR_W = $clog2(DEPTH) + 1;

    logic [NDIR-1:0][PTR_W-1:0] free_cnt;
    logic [NDIR-1:0]            wr_en, commit, rewind;

    torus_tx_ctrl #(.PTR_W(PTR_W), .MAX_DATA(MAX_DATA)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cpu_dir(cpu_dir), .cpu_resv(cpu_resv),
        .cpu_len(cpu_len), .cpu_resv_ok(cpu_resv_ok), .cpu_push(cpu_push),
        .cpu_commit(cpu_commit), .cpu_ovf_err(cpu_ovf_err), .free_cnt(free_cnt),
        .wr_en(wr_en), .commit(commit), .rewind(rewind)
    );

    for (genvar d = 0; d < NDIR; d++) begin : g_dir
        torus_tx_fifo #(.QW_W(QW_W), .DEPTH(DEPTH)) u_q (
            .clk(clk), .rst_n(rst_n), .wr_en(wr_en[d]), .wr_qw(cpu_qw),
            .commit(commit[d]), .rewind(rewind[d]), .free_cnt(free_cnt[d]),
            .out_valid(link_valid[d]), .out_qw(link_qw[d*QW_W +: QW_W]),
            .out_ready(link_ready[d])
        );
    end

    torus_rx_deframer #(.QW_W(QW_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .rx_valid_in(rx_valid_in), .rx_qw_in(rx_qw_in),
        .rx_ready_out(rx_ready_out), .rd_valid(rd_valid), .rd_qw(rd_qw),
        .rd_last(rd_last), .rd_ready(rd_ready)
    );
endmodule

// File: rtl/torus_link_port_chk.sv
module torus_link_port_chk #(
    parameter int QW_W = 128
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        cpu_len,
    input logic [2:0]        cpu_dir,
    input logic              cpu_resv,
    input logic              cpu_resv_ok,
    input logic              cpu_ovf_err,
    input logic [5:0]        link_valid,
    input logic [5:0]        link_ready,
    input logic [6*QW_W-1:0] link_qw,
    input logic              rd_valid,
    input logic              rd_ready,
    input logic              rd_last
);
    // R5
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ovf_err |=> cpu_ovf_err);

    // R2
    len_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_len > 4'd14) |-> !cpu_resv_ok);

    // R1
    dir_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_dir > 3'd5) |-> !cpu_resv_ok);

    // R2
    one_resv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_resv && cpu_resv_ok) |=> !cpu_resv_ok);

    // R8
    link_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (link_valid[0] && !link_ready[0]) |=> (link_valid[0] && $stable(link_qw[QW_W-1:0])));

    // R8
    link_hold_any_chk: assert property (@(posedge clk) disable iff (!rst_n)
        |(link_valid & ~link_ready) |=> ((link_valid & $past(link_valid & ~link_ready)) == $past(link_valid & ~link_ready)));

    // R6
    last_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_ready && rd_last) |=> !rd_valid);
endmodule

bind torus_link_port torus_link_port_chk #(.QW_W(QW_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_len(cpu_len), .cpu_dir(cpu_dir),
    .cpu_resv(cpu_resv), .cpu_resv_ok(cpu_resv_ok), .cpu_ovf_err(cpu_ovf_err),
    .link_valid(link_valid), .link_ready(link_ready), .link_qw(link_qw),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_last(rd_last)
);

// File: tb/test_torus_link_port.sv
module test_torus_link_port;
    localparam int QW = 128;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] cpu_dir = '0;
    logic cpu_resv = 1'b0;
    logic [3:0] cpu_len = '0;
    logic cpu_resv_ok;
    logic cpu_push = 1'b0;
    logic [QW-1:0] cpu_qw = '0;
    logic cpu_commit = 1'b0;
    logic cpu_ovf_err;
    logic [5:0] link_valid, link_ready;
    logic [6*QW-1:0] link_qw;
    logic rx_valid_in, rx_ready_out;
    logic [QW-1:0] rx_qw_in;
    logic rd_valid, rd_last;
    logic [QW-1:0] rd_qw;
    logic rd_ready = 1'b1;
    logic [2:0] lb_dir = '0;
    logic lb_en = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    assign rx_valid_in = lb_en && link_valid[lb_dir];
    assign rx_qw_in    = link_qw[lb_dir*QW +: QW];
    assign link_ready  = lb_en ? (6'(rx_ready_out) << lb_dir) : 6'b0;

    torus_link_port i_torus_link_port (
        .clk(clk), .rst_n(rst_n), .cpu_dir(cpu_dir), .cpu_resv(cpu_resv),
        .cpu_len(cpu_len), .cpu_resv_ok(cpu_resv_ok), .cpu_push(cpu_push),
        .cpu_qw(cpu_qw), .cpu_commit(cpu_commit), .cpu_ovf_err(cpu_ovf_err),
        .link_valid(link_valid), .link_ready(link_ready), .link_qw(link_qw),
        .rx_valid_in(rx_valid_in), .rx_qw_in(rx_qw_in), .rx_ready_out(rx_ready_out),
        .rd_valid(rd_valid), .rd_qw(rd_qw), .rd_last(rd_last), .rd_ready(rd_ready)
    );

    function automatic logic [QW-1:0] gen_qw(int p, int k);
        return {32'(p * 7919 + k), 32'(k * 31 + p), 32'hA5A5_0000 ^ 32'(p), 32'(p ^ (k << 8))};
    endfunction

    function automatic logic [QW-1:0] gen_hdr(int dir, int len);
        return {120'h0, 4'(len), 1'b0, 3'(dir)};
    endfunction

    function automatic bit exp_ok(int dir, int len, int free);
        return (dir < 6) && (len <= 14) && (free >= len + 1);
    endfunction

    task automatic chk(bit good, string req, string what, logic [QW-1:0] act, logic [QW-1:0] exp);
        n_chk++;
        if (!good) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic probe(int dir, int len, output bit ok);
        @(negedge clk);
        cpu_dir = 3'(dir); cpu_len = 4'(len);
        #1 ok = cpu_resv_ok;
    endtask

    task automatic reserve(int dir, int len, output bit ok);
        @(negedge clk);
        cpu_dir = 3'(dir); cpu_len = 4'(len); cpu_resv = 1'b1;
        #1 ok = cpu_resv_ok;
        @(negedge clk);
        cpu_resv = 1'b0;
    endtask

    task automatic push(logic [QW-1:0] q);
        @(negedge clk);
        cpu_push = 1'b1; cpu_qw = q;
        @(negedge clk);
        cpu_push = 1'b0;
    endtask

    task automatic do_commit();
        @(negedge clk);
        cpu_commit = 1'b1;
        @(negedge clk);
        cpu_commit = 1'b0;
    endtask

    task automatic send_pkt(int dir, int len, int p, int free);
        bit ok;
        reserve(dir, len, ok);
        chk(ok == exp_ok(dir, len, free), "R2", "reserve grant", QW'(ok), QW'(exp_ok(dir, len, free)));
        push(gen_hdr(dir, len));
        for (int k = 0; k < len; k++) push(gen_qw(p, k));
        do_commit();
    endtask

    task automatic recv_pkt(int dir, int len, int p);
        int k = 0;
        int t = 0;
        @(negedge clk);
        lb_dir = 3'(dir); lb_en = 1'b1;
        while (k < len && t < 80) begin
            @(negedge clk);
            t++;
            if (rd_valid) begin
                chk(rd_qw == gen_qw(p, k), "R3", "payload quadword (R6 header stripped)", rd_qw, gen_qw(p, k));
                chk(rd_last == (k == len - 1), "R6", "last flag", QW'(rd_last), QW'(k == len - 1));
                k++;
            end
        end
        chk(k == len, "R6", "payload count", QW'(k), QW'(len));
        repeat (3) @(negedge clk);
        chk(link_valid[dir] == 1'b0, "R8", "link drained", QW'(link_valid[dir]), 0);
        chk(rd_valid == 1'b0, "R7", "reader idle after packet", QW'(rd_valid), 0);
        lb_en = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        bit ok;
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9 reset state
        probe(0, 3, ok);
        chk(link_valid == 6'b0, "R9", "link_valid after reset", QW'(link_valid), 0);
        chk(rd_valid == 1'b0, "R9", "rd_valid after reset (R7)", QW'(rd_valid), 0);
        chk(cpu_ovf_err == 1'b0, "R9", "error after reset", QW'(cpu_ovf_err), 0);
        chk(ok == 1'b1, "R9", "reserve accepted after reset", QW'(ok), 1);

        // R1 invalid directions and R2 length limit
        probe(6, 1, ok); chk(ok == 1'b0, "R1", "dir 6 rejected", QW'(ok), 0);
        probe(7, 0, ok); chk(ok == 1'b0, "R1", "dir 7 rejected", QW'(ok), 0);
        probe(0, 15, ok); chk(ok == 1'b0, "R2", "length 15 rejected", QW'(ok), 0);

        // R4 invisibility, commit before header ignored
        reserve(1, 3, ok);
        chk(ok == 1'b1, "R2", "reserve dir1", QW'(ok), 1);
        do_commit();
        push(gen_hdr(1, 3));
        for (int k = 0; k < 3; k++) push(gen_qw(100, k));
        chk(link_valid == 6'b0, "R4", "uncommitted invisible", QW'(link_valid), 0);
        @(negedge clk); cpu_commit = 1'b1;
        @(negedge clk); cpu_commit = 1'b0;
        chk(link_valid == 6'b000010, "R4", "visible one cycle after commit", QW'(link_valid), QW'(6'b000010));
        chk(link_qw[QW +: QW] == gen_hdr(1, 3), "R3", "header first on link", link_qw[QW +: QW], gen_hdr(1, 3));
        recv_pkt(1, 3, 100);

        // R6 192-byte site payload and maximum length
        send_pkt(0, 12, 200, 16); recv_pkt(0, 12, 200);
        send_pkt(4, 14, 201, 16); recv_pkt(4, 14, 201);

        // R7 zero-length packet
        send_pkt(3, 0, 202, 16); recv_pkt(3, 0, 202);

        // R5 overflow
        reserve(2, 2, ok);
        push(gen_hdr(2, 2));
        push(gen_qw(300, 0)); push(gen_qw(300, 1));
        chk(cpu_ovf_err == 1'b0, "R5", "no error at reserved count", QW'(cpu_ovf_err), 0);
        push(gen_qw(300, 2));
        chk(cpu_ovf_err == 1'b1, "R5", "error on extra push", QW'(cpu_ovf_err), 1);
        do_commit();
        repeat (2) @(negedge clk);
        chk(link_valid[2] == 1'b0, "R5", "overflowed packet dropped", QW'(link_valid[2]), 0);
        send_pkt(2, 3, 301, 16); recv_pkt(2, 3, 301);
        chk(cpu_ovf_err == 1'b1, "R5", "error stays set", QW'(cpu_ovf_err), 1);

        // R2 room check on an undrained queue; rejected reservation ignored
        send_pkt(5, 14, 400, 16);
        probe(5, 1, ok); chk(ok == 1'b0, "R2", "no room for len 1", QW'(ok), 0);
        probe(5, 0, ok); chk(ok == 1'b1, "R2", "room for len 0", QW'(ok), 1);
        probe(0, 14, ok); chk(ok == 1'b1, "R1", "other queue unaffected", QW'(ok), 1);
        reserve(5, 1, ok);
        push(gen_hdr(5, 1)); push(gen_qw(401, 0)); do_commit();
        recv_pkt(5, 14, 400);

        // R3 R6 random traffic
        for (int i = 0; i < 24; i++) begin
            int d = int'($urandom % 6);
            int l = int'($urandom % 15);
            send_pkt(d, l, 500 + i, 16);
            recv_pkt(d, l, 500 + i);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule